// File: doc/BRIEF.md
# RGB LCD Timing Generator

This block produces the timing a parallel RGB LCD panel needs from a single video source clock. It drives horizontal sync, vertical sync, a data-enable strobe and a divided pixel clock. It also brings out the current horizontal and vertical positions, a one-cycle pixel advance strobe and a one-cycle frame-start strobe, so that a pixel pipeline can run in step with the panel.

Each line is made of four phases in a fixed order: sync pulse, back porch, active pixels, front porch. Each frame uses the same four phases, counted in lines. Every phase length is programmed as its value minus one. The pixel rate is the source clock divided by N+1, where N is the divider field. All counting moves forward only on divided pixel ticks. The timing fields and the divider are sampled when the block is enabled and again at each frame boundary, so a frame is always built from one consistent setting. Sync outputs are active-low by default. Each of the three strobes has its own polarity-invert bit.

Top module: `lcd_timing_gen`

## Requirements
- R1: From reset and while `en` is low, starting the cycle after `en` is sampled low: `lcd_hsync` and `lcd_vsync` sit at 1 XOR their invert bit, `lcd_de` at 0 XOR its invert bit, `lcd_pclk` is low, `h_pos` and `v_pos` are 0, and `frame_start` and `pix_tick` are low.
- R2: One pixel period lasts N+1 source clock cycles, with N = `cfg_div`. A `cfg_div` of 0 behaves exactly like 1.
- R3: Within each pixel period, `lcd_pclk` is high for the first floor((N+1)/2) source cycles and low for the remaining cycles.
- R4: `h_pos` steps by one per pixel period through 0 to Ht-1 and then wraps to 0. Ht = `cfg_hsw`+`cfg_hbp`+`cfg_hact`+`cfg_hfp`+4.
- R5: `lcd_hsync` is active (0 when its invert bit is 0) while `h_pos` <= `cfg_hsw`, and inactive otherwise.
- R6: `v_pos` steps by one each time `h_pos` wraps, runs through 0 to Vt-1 with Vt = `cfg_vsw`+`cfg_vbp`+`cfg_vact`+`cfg_vfp`+4, and then wraps to 0. `lcd_vsync` is active (0 when its invert bit is 0) while `v_pos` <= `cfg_vsw`.
- R7: `lcd_de` is active (1 when its invert bit is 0) only when both positions are in their active windows: `cfg_hsw`+`cfg_hbp`+2 <= `h_pos` <= `cfg_hsw`+`cfg_hbp`+`cfg_hact`+2, and the same rule holds vertically with the vertical fields.
- R8: `frame_start` is high for exactly one source cycle, the first cycle of each frame, and in that cycle `h_pos` = `v_pos` = 0.
- R9: The eight timing fields and `cfg_div` are sampled only in the cycle that enables the block and at each frame wrap. A change at any other time has no effect on the frame in progress and applies from the next frame.
- R10: Each of `cfg_inv_hs`, `cfg_inv_vs` and `cfg_inv_de` flips both the active and the inactive level of its output, starting the cycle after it changes.
- R11: The first cycle after `en` is sampled high opens a fresh frame: `h_pos` = `v_pos` = 0, both syncs are active and `frame_start` is high.
- R12: `pix_tick` is high for one source cycle in each cycle where the positions have just advanced. It is not raised in the first cycle after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds every output inactive |
| cfg_hsw | input | CW | Horizontal sync width minus one |
| cfg_hbp | input | CW | Horizontal back porch minus one |
| cfg_hact | input | CW | Active pixels per line minus one |
| cfg_hfp | input | CW | Horizontal front porch minus one |
| cfg_vsw | input | CW | Vertical sync width in lines minus one |
| cfg_vbp | input | CW | Vertical back porch minus one |
| cfg_vact | input | CW | Active lines per frame minus one |
| cfg_vfp | input | CW | Vertical front porch minus one |
| cfg_div | input | DW | Pixel clock divider N (period N+1; 0 treated as 1) |
| cfg_inv_hs | input | 1 | Invert horizontal sync polarity |
| cfg_inv_vs | input | 1 | Invert vertical sync polarity |
| cfg_inv_de | input | 1 | Invert data-enable polarity |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| lcd_pclk | output | 1 | Divided pixel clock |
| pix_tick | output | 1 | Positions advanced this cycle |
| frame_start | output | 1 | First cycle of a frame |
| h_pos | output | CW+2 | Horizontal position in pixels |
| v_pos | output | CW+2 | Vertical position in lines |

## Verification
A divider count that is off by one stretches or shrinks every pixel. This shows up in the first pixel period, both in the spacing of `pix_tick` and in the `lcd_pclk` duty, and it then shifts every later sync edge. A phase boundary decoded wrongly moves a sync or data-enable edge by one pixel at that position, which is visible within one line for horizontal faults and within one frame for vertical faults. A shadow register that reloads at the wrong time is harder to spot: it only shows when a mid-frame write makes the current frame take the new geometry, and that is why the write is placed between frame boundaries and compared edge for edge across the boundary that follows.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    // Phase of one axis, in the order it is traversed.
    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    // Number of axes (horizontal, vertical).
    localparam int NUM_AXES = 2;

endpackage

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    input  logic [DW-1:0] div_val,
    output logic          tick,
    output logic          pclk
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          pclk;
    } div_st_t;

    div_st_t       st_d, st_q;
    logic [DW-1:0] eff;
    logic [DW:0]   half;

    // A zero divider is not legal: fall back to the smallest legal value.
    assign eff  = (div_val == '0) ? DW'(1) : div_val;
    assign half = ({1'b0, eff} + (DW+1)'(1)) >> 1;
    assign tick = en && run && (st_q.cnt == eff);

    always_comb begin
        st_d = st_q;
        if (!(en && run) || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
        st_d.pclk = en && ({1'b0, st_d.cnt} < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pclk = st_q.pclk;

endmodule

// File: rtl/lcd_tg_phase.sv
module lcd_tg_phase
    import lcd_tg_pkg::*;
#(
    parameter int CW = 11,
    parameter int PW = CW + 2
) (
    input  logic [PW-1:0] pos,
    input  logic [CW-1:0] sw,
    input  logic [CW-1:0] bp,
    input  logic [CW-1:0] act,
    output phase_e        phase
);

    logic [PW-1:0] end_sync, end_back, end_act;

    // Exclusive end of each phase, fields held as value minus one.
    assign end_sync = PW'(sw) + PW'(1);
    assign end_back = end_sync + PW'(bp) + PW'(1);
    assign end_act  = end_back + PW'(act) + PW'(1);

    always_comb begin
        if (pos < end_sync) begin
            phase = PH_SYNC;
        end else if (pos < end_back) begin
            phase = PH_BACK;
        end else if (pos < end_act) begin
            phase = PH_ACTIVE;
        end else begin
            phase = PH_FRONT;
        end
    end

endmodule

// File: rtl/lcd_tg_span_end.sv
module lcd_tg_span_end #(
    parameter int CW = 11,
    parameter int PW = CW + 2
) (
    input  logic [PW-1:0] pos,
    input  logic [CW-1:0] sw,
    input  logic [CW-1:0] bp,
    input  logic [CW-1:0] act,
    input  logic [CW-1:0] fp,
    output logic          last
);

    logic [PW-1:0] total_m1;

    assign total_m1 = PW'(sw) + PW'(bp) + PW'(act) + PW'(fp) + PW'(3);
    assign last     = (pos == total_m1);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int CW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cfg_hsw,
    input  logic [CW-1:0] cfg_hbp,
    input  logic [CW-1:0] cfg_hact,
    input  logic [CW-1:0] cfg_hfp,
    input  logic [CW-1:0] cfg_vsw,
    input  logic [CW-1:0] cfg_vbp,
    input  logic [CW-1:0] cfg_vact,
    input  logic [CW-1:0] cfg_vfp,
    input  logic [DW-1:0] cfg_div,
    input  logic          cfg_inv_hs,
    input  logic          cfg_inv_vs,
    input  logic          cfg_inv_de,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic          lcd_pclk,
    output logic          pix_tick,
    output logic          frame_start,
    output logic [CW+1:0] h_pos,
    output logic [CW+1:0] v_pos
);

    localparam int PW = CW + 2;

    typedef struct packed {
        logic [CW-1:0] hsw;
        logic [CW-1:0] hbp;
        logic [CW-1:0] hact;
        logic [CW-1:0] hfp;
        logic [CW-1:0] vsw;
        logic [CW-1:0] vbp;
        logic [CW-1:0] vact;
        logic [CW-1:0] vfp;
        logic [DW-1:0] div;
    } cfg_t;

    typedef struct packed {
        logic          run;
        cfg_t          wcfg;
        logic [PW-1:0] h;
        logic [PW-1:0] v;
        logic          tk;
        logic          fs;
    } cnt_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } out_t;

    cnt_t  cnt_d, cnt_q;
    out_t  out_d, out_q;
    cfg_t  cfg_in;
    logic  tick;

    // Per-axis views: index 0 horizontal, 1 vertical; fields [0]=sw .. [3]=fp.
    logic [NUM_AXES-1:0][3:0][CW-1:0] fld_q, fld_d;
    logic [NUM_AXES-1:0][PW-1:0]      pos_q, pos_d;
    logic [NUM_AXES-1:0]              at_end;
    phase_e                           ph_d [NUM_AXES];

    assign cfg_in = '{hsw: cfg_hsw, hbp: cfg_hbp, hact: cfg_hact, hfp: cfg_hfp,
                      vsw: cfg_vsw, vbp: cfg_vbp, vact: cfg_vact, vfp: cfg_vfp,
                      div: cfg_div};

    assign fld_q[0] = {cnt_q.wcfg.hfp, cnt_q.wcfg.hact, cnt_q.wcfg.hbp, cnt_q.wcfg.hsw};
    assign fld_q[1] = {cnt_q.wcfg.vfp, cnt_q.wcfg.vact, cnt_q.wcfg.vbp, cnt_q.wcfg.vsw};
    assign fld_d[0] = {cnt_d.wcfg.hfp, cnt_d.wcfg.hact, cnt_d.wcfg.hbp, cnt_d.wcfg.hsw};
    assign fld_d[1] = {cnt_d.wcfg.vfp, cnt_d.wcfg.vact, cnt_d.wcfg.vbp, cnt_d.wcfg.vsw};
    assign pos_q[0] = cnt_q.h;
    assign pos_q[1] = cnt_q.v;
    assign pos_d[0] = cnt_d.h;
    assign pos_d[1] = cnt_d.v;

    lcd_tg_pixdiv #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .run     (cnt_q.run),
        .div_val (cnt_q.wcfg.div),
        .tick    (tick),
        .pclk    (lcd_pclk)
    );

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        // End-of-span test on the current position and working fields.
        lcd_tg_span_end #(.CW(CW), .PW(PW)) u_end (
            .pos  (pos_q[a]),
            .sw   (fld_q[a][0]),
            .bp   (fld_q[a][1]),
            .act  (fld_q[a][2]),
            .fp   (fld_q[a][3]),
            .last (at_end[a])
        );
        // Phase of the next position, so the strobes leave a register.
        lcd_tg_phase #(.CW(CW), .PW(PW)) u_phase (
            .pos   (pos_d[a]),
            .sw    (fld_d[a][0]),
            .bp    (fld_d[a][1]),
            .act   (fld_d[a][2]),
            .phase (ph_d[a])
        );
    end

    // Next-state of the counters and the working timing set.
    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.run = en;
        cnt_d.tk  = 1'b0;
        cnt_d.fs  = 1'b0;
        if (!en) begin
            cnt_d.h    = '0;
            cnt_d.v    = '0;
            cnt_d.wcfg = cfg_in;
        end else if (!cnt_q.run) begin
            cnt_d.h    = '0;
            cnt_d.v    = '0;
            cnt_d.wcfg = cfg_in;
            cnt_d.fs   = 1'b1;
        end else if (tick) begin
            cnt_d.tk = 1'b1;
            if (at_end[0]) begin
                cnt_d.h = '0;
                if (at_end[1]) begin
                    cnt_d.v    = '0;
                    cnt_d.wcfg = cfg_in;
                    cnt_d.fs   = 1'b1;
                end else begin
                    cnt_d.v = cnt_q.v + PW'(1);
                end
            end else begin
                cnt_d.h = cnt_q.h + PW'(1);
            end
        end
    end

    // Strobe levels for the next cycle.
    always_comb begin
        out_d.hs = !(en && (ph_d[0] == PH_SYNC)) ^ cfg_inv_hs;
        out_d.vs = !(en && (ph_d[1] == PH_SYNC)) ^ cfg_inv_vs;
        out_d.de = (en && (ph_d[0] == PH_ACTIVE) && (ph_d[1] == PH_ACTIVE)) ^ cfg_inv_de;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= '{hs: 1'b1, vs: 1'b1, de: 1'b0};
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    assign lcd_hsync   = out_q.hs;
    assign lcd_vsync   = out_q.vs;
    assign lcd_de      = out_q.de;
    assign pix_tick    = cnt_q.tk;
    assign frame_start = cnt_q.fs;
    assign h_pos       = cnt_q.h;
    assign v_pos       = cnt_q.v;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
    parameter int PW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          cfg_inv_de,
    input logic          lcd_de,
    input logic          lcd_pclk,
    input logic          pix_tick,
    input logic          frame_start,
    input logic [PW-1:0] h_pos,
    input logic [PW-1:0] v_pos
);

    // R1: a disabled block rests at the origin with idle strobes.
    a_r1_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |->
            (h_pos == '0 && v_pos == '0 && !frame_start && !pix_tick &&
             !lcd_pclk && lcd_de == $past(cfg_inv_de)));

    // R3: the pixel clock is high in the first cycle of every pixel.
    a_r3_tick_pclk_high: assert property (@(posedge clk) disable iff (!rst_n)
        pix_tick |-> lcd_pclk);

    // R4: an advance that does not wrap moves h_pos by exactly one.
    a_r4_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && pix_tick && h_pos != '0) |-> (h_pos == $past(h_pos) + PW'(1)));

    // R6: a line wrap inside a frame moves v_pos by exactly one.
    a_r6_v_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && pix_tick && h_pos == '0 && !frame_start) |->
            (v_pos == $past(v_pos) + PW'(1)));

    // R8: frame start only at the origin, at the opening of a pixel.
    a_r8_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (h_pos == '0 && v_pos == '0 && lcd_pclk));

    // R12: without an advance strobe the positions hold.
    a_r12_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !pix_tick) |-> ($stable(h_pos) && $stable(v_pos)));

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.PW(CW + 2)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cfg_inv_de  (cfg_inv_de),
    .lcd_de      (lcd_de),
    .lcd_pclk    (lcd_pclk),
    .pix_tick    (pix_tick),
    .frame_start (frame_start),
    .h_pos       (h_pos),
    .v_pos       (v_pos)
);

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;

    localparam int CW = 11;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [CW-1:0] cfg_hsw, cfg_hbp, cfg_hact, cfg_hfp;
    logic [CW-1:0] cfg_vsw, cfg_vbp, cfg_vact, cfg_vfp;
    logic [DW-1:0] cfg_div;
    logic          cfg_inv_hs, cfg_inv_vs, cfg_inv_de;
    logic          lcd_hsync, lcd_vsync, lcd_de, lcd_pclk, pix_tick, frame_start;
    logic [CW+1:0] h_pos, v_pos;

    int checks   = 0;
    int failures = 0;
    int kf       = 0;
    bit firstc   = 1'b0;
    int m  [9];
    int pm [9];
    bit pend = 1'b0;

    always #4 clk = ~clk;

    lcd_timing_gen #(.CW(CW), .DW(DW)) u_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
        .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .cfg_div(cfg_div), .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs),
        .cfg_inv_de(cfg_inv_de), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .lcd_pclk(lcd_pclk), .pix_tick(pix_tick),
        .frame_start(frame_start), .h_pos(h_pos), .v_pos(v_pos)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int c[9]);
        cfg_hsw  = CW'(c[0]); cfg_hbp = CW'(c[1]); cfg_hact = CW'(c[2]); cfg_hfp = CW'(c[3]);
        cfg_vsw  = CW'(c[4]); cfg_vbp = CW'(c[5]); cfg_vact = CW'(c[6]); cfg_vfp = CW'(c[7]);
        cfg_div  = DW'(c[8]);
    endtask

    task automatic setcfg(input int c[9]);
        drive(c);
        m = c;
        pend = 1'b0;
    endtask

    // Idle levels after en low (R1), sampled the cycle after.
    task automatic check_idle(input string sc);
        int hs_e, vs_e, de_e;
        hs_e = 1 ^ int'(cfg_inv_hs);
        vs_e = 1 ^ int'(cfg_inv_vs);
        de_e = int'(cfg_inv_de);
        chk(lcd_hsync == hs_e[0], "R1", {sc, " hsync idle"}, int'(lcd_hsync), hs_e);
        chk(lcd_vsync == vs_e[0], "R1", {sc, " vsync idle"}, int'(lcd_vsync), vs_e);
        chk(lcd_de == de_e[0], "R1", {sc, " de idle"}, int'(lcd_de), de_e);
        chk(!lcd_pclk && !pix_tick && !frame_start, "R1", {sc, " pclk/tick/fs idle"},
            int'({lcd_pclk, pix_tick, frame_start}), 0);
        chk(h_pos == '0 && v_pos == '0, "R1", {sc, " positions idle"},
            int'(h_pos) + int'(v_pos), 0);
    endtask

    // Raise en; the next cycle must open a fresh frame (R11).
    task automatic start_run(input string sc);
        en = 1'b1;
        @(negedge clk);
        kf     = 0;
        firstc = 1'b1;
        chk(h_pos == '0 && v_pos == '0 && frame_start &&
            lcd_hsync == cfg_inv_hs && lcd_vsync == cfg_inv_vs,
            "R11", {sc, " fresh frame on enable"},
            int'({frame_start, lcd_hsync, lcd_vsync}),
            int'({1'b1, cfg_inv_hs, cfg_inv_vs}));
    endtask

    // Cycle-by-cycle comparison against a model built from the requirements.
    task automatic check_cycles(input int n, input int chg_at, input int nc[9],
                                input string sc, output int tot);
        int    bad [8];
        int    fa  [8];
        int    fe  [8];
        int    e   [8];
        int    a   [8];
        string tag [8];
        tag = '{"R5 hsync", "R6 vsync", "R7 de", "R3 pclk",
                "R4 h_pos", "R6 v_pos", "R8 frame_start", "R12 pix_tick"};
        for (int j = 0; j < 8; j++) begin
            bad[j] = 0; fa[j] = 0; fe[j] = 0;
        end
        for (int i = 0; i < n; i++) begin
            int nn, per, ht, vt, len, p, ph, hh, vv;
            bit ha, va;
            nn  = (m[8] == 0) ? 1 : m[8];
            per = nn + 1;
            ht  = m[0] + m[1] + m[2] + m[3] + 4;
            vt  = m[4] + m[5] + m[6] + m[7] + 4;
            len = ht * vt * per;
            p   = kf / per;
            ph  = kf % per;
            hh  = p % ht;
            vv  = p / ht;
            ha  = (hh >= m[0] + m[1] + 2) && (hh <= m[0] + m[1] + m[2] + 2);
            va  = (vv >= m[4] + m[5] + 2) && (vv <= m[4] + m[5] + m[6] + 2);
            e[0] = ((hh <= m[0]) ? 0 : 1) ^ int'(cfg_inv_hs);
            e[1] = ((vv <= m[4]) ? 0 : 1) ^ int'(cfg_inv_vs);
            e[2] = int'(ha && va) ^ int'(cfg_inv_de);
            e[3] = (ph < per / 2) ? 1 : 0;
            e[4] = hh;
            e[5] = vv;
            e[6] = (kf == 0) ? 1 : 0;
            e[7] = (ph == 0 && !firstc) ? 1 : 0;
            a[0] = int'(lcd_hsync); a[1] = int'(lcd_vsync); a[2] = int'(lcd_de);
            a[3] = int'(lcd_pclk);  a[4] = int'(h_pos);     a[5] = int'(v_pos);
            a[6] = int'(frame_start); a[7] = int'(pix_tick);
            for (int j = 0; j < 8; j++) begin
                if (a[j] != e[j]) begin
                    if (bad[j] == 0) begin
                        fa[j] = a[j]; fe[j] = e[j];
                    end
                    bad[j]++;
                end
            end
            if (i == chg_at) begin
                drive(nc);
                pm   = nc;
                pend = 1'b1;
            end
            @(negedge clk);
            kf++;
            firstc = 1'b0;
            if (kf == len) begin
                kf = 0;
                if (pend) begin
                    m    = pm;
                    pend = 1'b0;
                end
            end
        end
        tot = 0;
        for (int j = 0; j < 8; j++) begin
            chk(bad[j] == 0, tag[j], sc, fa[j], fe[j]);
            tot += bad[j];
        end
    endtask

    // Source cycles between two consecutive advance strobes (R2).
    task automatic measure_period(input int exp, input string sc);
        int cnt;
        int guard;
        guard = 0;
        while (!pix_tick && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!pix_tick && cnt < 1000);
        chk(cnt == exp, "R2", {sc, " pixel period"}, cnt, exp);
    endtask

    task automatic stop_run(input string sc);
        en = 1'b0;
        @(negedge clk);
        check_idle(sc);
    endtask

    int cfg_a  [9] = '{0, 1, 3, 0, 0, 0, 2, 1, 1};
    int cfg_a0 [9] = '{0, 1, 3, 0, 0, 0, 2, 1, 0};
    int cfg_b  [9] = '{2, 0, 4, 1, 1, 0, 3, 0, 3};
    int cfg_c  [9] = '{1, 0, 2, 0, 0, 1, 1, 0, 2};

    task automatic t_reset();
        check_idle("reset");
    endtask

    task automatic t_basic();
        int tot;
        setcfg(cfg_a);
        start_run("basic");
        check_cycles(2 * 112 + 10, -1, cfg_a, "basic two frames", tot);
        measure_period(2, "basic div=1");
        stop_run("basic stop");
    endtask

    task automatic t_div_zero();
        int tot;
        setcfg(cfg_a0);
        start_run("div0");
        check_cycles(120, -1, cfg_a0, "div=0 as 1", tot);
        measure_period(2, "div=0 treated as 1");
        stop_run("div0 stop");
    endtask

    task automatic t_inverted();
        int tot;
        setcfg(cfg_b);
        cfg_inv_hs = 1'b1; cfg_inv_vs = 1'b1; cfg_inv_de = 1'b1;
        @(negedge clk);
        chk(lcd_hsync == 1'b0 && lcd_vsync == 1'b0 && lcd_de == 1'b1, "R10",
            "inverted idle levels", int'({lcd_hsync, lcd_vsync, lcd_de}), 1);
        start_run("inverted");
        check_cycles(352 + 30, -1, cfg_b, "inverted div=3", tot);
        chk(tot == 0, "R10", "inverted frame mismatches", tot, 0);
        measure_period(4, "div=3");
        stop_run("inverted stop");
        cfg_inv_hs = 1'b0; cfg_inv_vs = 1'b0; cfg_inv_de = 1'b0;
        @(negedge clk);
        chk(lcd_hsync && lcd_vsync && !lcd_de, "R10", "polarity restored",
            int'({lcd_hsync, lcd_vsync, lcd_de}), 6);
    endtask

    task automatic t_shadow();
        int tot;
        setcfg(cfg_a);
        start_run("shadow");
        check_cycles(112 + 126 + 20, 50, cfg_c, "mid-frame rewrite", tot);
        chk(tot == 0, "R9", "new timing only from next frame", tot, 0);
        stop_run("shadow stop");
    endtask

    task automatic t_mid_disable();
        int tot;
        setcfg(cfg_a);
        start_run("midline");
        check_cycles(37, -1, cfg_a, "before disable", tot);
        stop_run("disable mid-line");
        repeat (5) @(negedge clk);
        check_idle("held disabled");
        start_run("re-enable");
        check_cycles(30, -1, cfg_a, "after re-enable", tot);
        stop_run("final stop");
    endtask

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        cfg_inv_hs = 1'b0; cfg_inv_vs = 1'b0; cfg_inv_de = 1'b0;
        setcfg(cfg_a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_div_zero();
        t_inverted();
        t_shadow();
        t_mid_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule